// File: doc/BRIEF.md
# Microcontroller Stack Pointer Engine

This block keeps the 8-bit stack pointer of a small 8-bit microcontroller and drives the data-SRAM side of every stack transfer. A requester (the core's execute stage) issues one of four operations: push a data byte, pop a data byte, save a two-byte return address (for a subroutine call or an interrupt entry), or restore a two-byte return address (for a return from subroutine or interrupt). The block presents the SRAM address, write strobe and write data, steps the pointer, and hands back the popped byte or the rebuilt return address.

Software sees the pointer as a single read/write I/O register. The data space is only 224 bytes, so eight bits cover it, and the pointer arithmetic wraps modulo 256. After reset the pointer is zero, so software has to load it before the first call or interrupt. A valid stack lives above data address 0x60; a status output warns whenever a stack write lands at or below that floor.

The controller is a three-state machine. `ST_IDLE` accepts requests. A save moves `ST_IDLE -> ST_SAVE_HI -> ST_IDLE`, and a restore moves `ST_IDLE -> ST_REST_LO -> ST_IDLE`. Push and pop complete in `ST_IDLE` and take no transition. `busy` is high in both second-cycle states.

Top module: `stk_ptr_engine`

## Requirements
- R1: After reset the pointer reads 0x00, `busy`, `mem_we`, `pop_valid`, `ret_done` and `stack_low` are low, and no SRAM write happens while the block is idle without a request.
- R2: The pointer is read and written at I/O address 0x3D. A write there with no stack activity loads `io_wdata` into all 8 bits. A read there returns the pointer. Other I/O addresses read as 0x00 and writes to them leave the pointer unchanged.
- R3: A push (`op_code` 0) writes `push_data` at the current pointer SP in the accepting cycle, and then the pointer becomes SP-1.
- R4: A pop (`op_code` 1) reads address SP+1 in the accepting cycle, and the pointer becomes SP+1. On the following cycle `pop_valid` pulses for one cycle with `pop_data` holding that byte.
- R5: A save (`op_code` 2) takes two cycles. The first writes `ret_addr_in[7:0]` at SP. The second, with `busy` high, writes `ret_addr_in[15:8]` at SP-1. The pointer ends at SP-2.
- R6: A restore (`op_code` 3) takes two cycles. It reads the high byte at SP+1 first, then the low byte at SP+2, with `busy` high in the second cycle. The pointer ends at SP+2. One cycle after the second read, `ret_done` pulses for one cycle and `ret_addr_out` holds the full address.
- R7: A request raised while `busy` is high is ignored. It writes nothing and does not move the pointer.
- R8: An I/O write to 0x3D is dropped in any cycle in which a stack operation is accepted or a two-cycle transfer is in progress. The stack operation's pointer update wins.
- R9: `stack_low` is high in every cycle in which the block writes the SRAM at an address less than or equal to 0x60, and low otherwise.
- R10: Pointer arithmetic wraps modulo 256. A push at 0x00 leaves 0xFF, and a pop at 0xFF reads 0x00 and leaves 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Stack operation request |
| op_code | input | 2 | 0 push, 1 pop, 2 save return address, 3 restore return address |
| push_data | input | 8 | Byte to push |
| ret_addr_in | input | 16 | Return address to save |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (pointer at 0x3D, otherwise 0) |
| mem_addr | output | 8 | SRAM address |
| mem_we | output | 1 | SRAM write strobe |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data (combinational from `mem_addr`) |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | One-cycle pulse: `pop_data` is valid |
| ret_addr_out | output | 16 | Restored return address |
| ret_done | output | 1 | One-cycle pulse: `ret_addr_out` is valid |
| busy | output | 1 | Two-cycle transfer in its second cycle |
| stack_low | output | 1 | Current SRAM write is at or below the stack floor |

## Verification
A pointer that steps wrongly shows on `io_rdata` in the cycle after the operation. It also shows on `mem_addr` at the next stack access, because every address the block issues is derived from the pointer. A state machine that sticks in a second-cycle state leaves `busy` high and swallows the next request, which is visible one cycle later. A wrong byte order in a save or restore shows up only when the pair is read back: as a swapped `ret_addr_out` two cycles after the restore request, or as SRAM contents that differ from the expected layout right after the save. The bench sweeps every starting pointer value, so each of these faults appears within a few hundred cycles.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        OP_PUSH    = 2'd0,
        OP_POP     = 2'd1,
        OP_SAVE    = 2'd2,
        OP_RESTORE = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAVE_HI = 2'd1,
        ST_REST_LO = 2'd2
    } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
// Pointer register: stack steps win over the I/O load port.
module stk_ptr #(
    parameter int DW = 8,
    parameter int IO_AW = 6,
    parameter logic [IO_AW-1:0] SP_IO_ADDR = 6'h3D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_dec,
    input  logic             step_inc,
    input  logic             stack_act,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_wr,
    input  logic [DW-1:0]    io_wdata,
    output logic [DW-1:0]    sp,
    output logic [DW-1:0]    io_rdata
);
    logic io_hit;
    assign io_hit = (io_addr == SP_IO_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= '0;
        else if (step_dec)
            sp <= sp - DW'(1);
        else if (step_inc)
            sp <= sp + DW'(1);
        else if (io_wr && io_hit && !stack_act)
            sp <= io_wdata;
    end

    assign io_rdata = io_hit ? sp : '0;
endmodule

// File: rtl/stk_lowmark.sv
// Flags SRAM writes that land at or below the stack floor.
module stk_lowmark #(
    parameter int DW = 8,
    parameter logic [DW-1:0] FLOOR = 8'h60
) (
    input  logic          we,
    input  logic [DW-1:0] addr,
    output logic          low
);
    assign low = we && (addr <= FLOOR);
endmodule

// File: rtl/stk_ctrl.sv
// Transfer sequencer: single-byte ops in IDLE, two-byte ops over two states.
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  stk_op_e         op_code,
    input  logic [DW-1:0]   push_data,
    input  logic [2*DW-1:0] ret_in,
    input  logic [DW-1:0]   sp,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [DW-1:0]   mem_wdata,
    output logic            sp_dec,
    output logic            sp_inc,
    output logic            stack_act,
    output logic            busy,
    output logic [DW-1:0]   pop_data,
    output logic            pop_valid,
    output logic [2*DW-1:0] ret_out,
    output logic            ret_done
);
    stk_state_e state_q, state_d;
    logic [DW-1:0] hi_wr_q;
    logic [DW-1:0] hi_rd_q;
    logic take_pop, take_hi, take_lo, keep_hi;
    logic [DW-1:0] sp_up;

    assign sp_up = sp + DW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        mem_addr  = sp;
        mem_we    = 1'b0;
        mem_wdata = '0;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        stack_act = 1'b0;
        take_pop  = 1'b0;
        take_hi   = 1'b0;
        take_lo   = 1'b0;
        keep_hi   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    stack_act = 1'b1;
                    unique case (op_code)
                        OP_PUSH: begin
                            mem_we    = 1'b1;
                            mem_wdata = push_data;
                            sp_dec    = 1'b1;
                        end
                        OP_POP: begin
                            mem_addr = sp_up;
                            sp_inc   = 1'b1;
                            take_pop = 1'b1;
                        end
                        OP_SAVE: begin
                            mem_we    = 1'b1;
                            mem_wdata = ret_in[DW-1:0];
                            sp_dec    = 1'b1;
                            keep_hi   = 1'b1;
                            state_d   = ST_SAVE_HI;
                        end
                        OP_RESTORE: begin
                            mem_addr = sp_up;
                            sp_inc   = 1'b1;
                            take_hi  = 1'b1;
                            state_d  = ST_REST_LO;
                        end
                    endcase
                end
            end
            ST_SAVE_HI: begin
                stack_act = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hi_wr_q;
                sp_dec    = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_REST_LO: begin
                stack_act = 1'b1;
                mem_addr  = sp_up;
                sp_inc    = 1'b1;
                take_lo   = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid <= 1'b0;
            ret_done  <= 1'b0;
            pop_data  <= '0;
            ret_out   <= '0;
            hi_wr_q   <= '0;
            hi_rd_q   <= '0;
        end else begin
            pop_valid <= take_pop;
            ret_done  <= take_lo;
            if (take_pop) pop_data <= mem_rdata;
            if (keep_hi)  hi_wr_q  <= ret_in[2*DW-1:DW];
            if (take_hi)  hi_rd_q  <= mem_rdata;
            if (take_lo)  ret_out  <= {hi_rd_q, mem_rdata};
        end
    end
endmodule

// File: rtl/stk_ptr_engine.sv
module stk_ptr_engine #(
    parameter int DW = 8,
    parameter int IO_AW = 6,
    parameter logic [IO_AW-1:0] SP_IO_ADDR = 6'h3D,
    parameter logic [DW-1:0] STACK_FLOOR = 8'h60
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_code,
    input  logic [DW-1:0]   push_data,
    input  logic [2*DW-1:0] ret_addr_in,
    input  logic [IO_AW-1:0] io_addr,
    input  logic            io_wr,
    input  logic [DW-1:0]   io_wdata,
    output logic [DW-1:0]   io_rdata,
    output logic [DW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   pop_data,
    output logic            pop_valid,
    output logic [2*DW-1:0] ret_addr_out,
    output logic            ret_done,
    output logic            busy,
    output logic            stack_low
);
    logic [DW-1:0] sp_w;
    logic dec_w, inc_w, act_w;

    stk_ctrl #(.DW(DW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (stk_pkg::stk_op_e'(op_code)),
        .push_data (push_data),
        .ret_in    (ret_addr_in),
        .sp        (sp_w),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .sp_dec    (dec_w),
        .sp_inc    (inc_w),
        .stack_act (act_w),
        .busy      (busy),
        .pop_data  (pop_data),
        .pop_valid (pop_valid),
        .ret_out   (ret_addr_out),
        .ret_done  (ret_done)
    );

    stk_ptr #(.DW(DW), .IO_AW(IO_AW), .SP_IO_ADDR(SP_IO_ADDR)) ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_dec  (dec_w),
        .step_inc  (inc_w),
        .stack_act (act_w),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata),
        .sp        (sp_w),
        .io_rdata  (io_rdata)
    );

    stk_lowmark #(.DW(DW), .FLOOR(STACK_FLOOR)) low_i (
        .we   (mem_we),
        .addr (mem_addr),
        .low  (stack_low)
    );
endmodule

// File: rtl/stk_ptr_engine_chk.sv
module stk_ptr_engine_chk #(
    parameter int DW = 8,
    parameter int IO_AW = 6,
    parameter logic [IO_AW-1:0] SP_IO_ADDR = 6'h3D,
    parameter logic [DW-1:0] STACK_FLOOR = 8'h60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [1:0]       op_code,
    input logic [DW-1:0]    push_data,
    input logic [IO_AW-1:0] io_addr,
    input logic             io_wr,
    input logic [DW-1:0]    io_wdata,
    input logic [DW-1:0]    mem_addr,
    input logic             mem_we,
    input logic [DW-1:0]    mem_wdata,
    input logic             pop_valid,
    input logic             ret_done,
    input logic             busy,
    input logic             stack_low,
    input logic [DW-1:0]    sp
);
    logic acc;
    assign acc = op_valid && !busy;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !op_valid) |-> !mem_we);

    assert_io_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == SP_IO_ADDR && !op_valid && !busy) |=> sp == $past(io_wdata));

    assert_push_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_code == 2'd0) |-> (mem_we && mem_addr == sp && mem_wdata == push_data));

    assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_code == 2'd0) |=> sp == DW'($past(sp) - DW'(1)));

    assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_code == 2'd1) |=> (sp == DW'($past(sp) + DW'(1)) && pop_valid));

    assert_save_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_code == 2'd2) |=> (busy && mem_we));

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |-> $past(busy));

    assert_busy_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_low_on_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_code == 2'd0 && sp <= STACK_FLOOR) |-> stack_low);

    assert_low_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stack_low |-> mem_we);
endmodule

bind stk_ptr_engine stk_ptr_engine_chk #(
    .DW(DW), .IO_AW(IO_AW), .SP_IO_ADDR(SP_IO_ADDR), .STACK_FLOOR(STACK_FLOOR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .push_data (push_data),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .pop_valid (pop_valid),
    .ret_done  (ret_done),
    .busy      (busy),
    .stack_low (stack_low),
    .sp        (sp_w)
);

// File: tb/stk_ptr_engine_tb_top.sv
`timescale 1ns/1ps
module stk_ptr_engine_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [1:0] op_code = 2'd0;
    logic [7:0] push_data = 8'h00;
    logic [15:0] ret_addr_in = 16'h0000;
    logic [5:0] io_addr = 6'h3D;
    logic io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata, mem_addr, mem_wdata, mem_rdata, pop_data;
    logic mem_we, pop_valid, ret_done, busy, stack_low;
    logic [15:0] ret_addr_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mem [0:255];

    always #10 clk = ~clk;

    stk_ptr_engine dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .push_data(push_data), .ret_addr_in(ret_addr_in), .io_addr(io_addr),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pop_data(pop_data), .pop_valid(pop_valid),
        .ret_addr_out(ret_addr_out), .ret_done(ret_done), .busy(busy),
        .stack_low(stack_low)
    );

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem[mem_addr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_sp(input logic [7:0] v);
        @(negedge clk);
        io_addr = 6'h3D; io_wr = 1'b1; io_wdata = v;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic issue(input logic [1:0] code);
        @(negedge clk);
        op_valid = 1'b1; op_code = code;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 sp", io_rdata, 8'h00);
        chk("R1 busy", busy, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 pop_valid", pop_valid, 0);
        chk("R1 ret_done", ret_done, 0);
        chk("R1 stack_low", stack_low, 0);

        // R2: other I/O addresses
        set_sp(8'hB4);
        chk("R2 load", io_rdata, 8'hB4);
        @(negedge clk);
        io_addr = 6'h3C; io_wr = 1'b1; io_wdata = 8'h11;
        #1 chk("R2 other read", io_rdata, 8'h00);
        @(negedge clk);
        io_wr = 1'b0; io_addr = 6'h3D;
        #1 chk("R2 other write ignored", io_rdata, 8'hB4);

        // Sweep every starting pointer: R2 R3 R4 R5 R6 R9
        for (int s = 0; s < 256; s++) begin
            logic [7:0] sv, d;
            logic [15:0] ra;
            sv = 8'(s);
            d = sv ^ 8'h3C;
            ra = {sv ^ 8'hC5, 8'(sv + 8'd7)};
            set_sp(sv);
            #1 chk("R2 sweep load", io_rdata, sv);

            issue(2'd0); push_data = d;
            #1 chk("R9 push flag", stack_low, (sv <= 8'h60));
            chk("R3 push addr", mem_addr, sv);
            @(negedge clk);
            op_valid = 1'b0;
            #1 chk("R3 push data", mem[sv], d);
            chk("R3 push sp", io_rdata, 8'(sv - 8'd1));

            issue(2'd1);
            @(negedge clk);
            op_valid = 1'b0;
            #1 chk("R4 pop valid", pop_valid, 1);
            chk("R4 pop data", pop_data, d);
            chk("R4 pop sp", io_rdata, sv);

            issue(2'd2); ret_addr_in = ra;
            @(negedge clk);
            op_valid = 1'b0;
            #1 chk("R5 busy", busy, 1);
            chk("R9 save hi flag", stack_low, (8'(sv - 8'd1) <= 8'h60));
            @(negedge clk);
            #1 chk("R5 low byte", mem[sv], ra[7:0]);
            chk("R5 high byte", mem[8'(sv - 8'd1)], ra[15:8]);
            chk("R5 sp", io_rdata, 8'(sv - 8'd2));
            chk("R5 idle", busy, 0);

            issue(2'd3);
            @(negedge clk);
            op_valid = 1'b0;
            #1 chk("R6 busy", busy, 1);
            chk("R6 no done yet", ret_done, 0);
            @(negedge clk);
            #1 chk("R6 done", ret_done, 1);
            chk("R6 addr", ret_addr_out, ra);
            chk("R6 sp", io_rdata, sv);
            @(negedge clk);
            #1 chk("R6 done pulse", ret_done, 0);
        end

        // R7: request during busy ignored
        set_sp(8'h90);
        mem[8'h8E] = 8'h5A;
        issue(2'd2); ret_addr_in = 16'h1234;
        @(negedge clk);
        op_code = 2'd0; push_data = 8'hEE;
        @(negedge clk);
        op_valid = 1'b0;
        #1 chk("R7 sp", io_rdata, 8'h8E);
        chk("R7 high kept", mem[8'h8F], 8'h12);
        chk("R7 no extra write", mem[8'h8E], 8'h5A);

        // R8: I/O write collides with stack op
        set_sp(8'hA0);
        issue(2'd0); push_data = 8'h77;
        io_wr = 1'b1; io_wdata = 8'h33;
        @(negedge clk);
        op_valid = 1'b0; io_wr = 1'b0;
        #1 chk("R8 accept beats io", io_rdata, 8'h9F);
        issue(2'd3);
        @(negedge clk);
        op_valid = 1'b0; io_wr = 1'b1; io_wdata = 8'h44;
        @(negedge clk);
        io_wr = 1'b0;
        #1 chk("R8 busy beats io", io_rdata, 8'hA1);

        // R10: wrap
        set_sp(8'h00);
        issue(2'd0); push_data = 8'h21;
        @(negedge clk);
        op_valid = 1'b0;
        #1 chk("R10 push wrap", io_rdata, 8'hFF);
        mem[8'h00] = 8'hC3;
        set_sp(8'hFF);
        issue(2'd1);
        #1 chk("R10 pop addr", mem_addr, 8'h00);
        @(negedge clk);
        op_valid = 1'b0;
        #1 chk("R10 pop wrap", io_rdata, 8'h00);
        chk("R10 pop data", pop_data, 8'hC3);

        finish_run();
    end
endmodule